// File: doc/BRIEF.md
# Translation Cache with Masked Flush

This block is a small fully associative cache of address translations. Each slot holds a valid flag, a 4-bit function code, a task alias, a logical page tag, a physical page number and a shared flag. A shared slot belongs to every task. A lookup compares all slots in parallel and returns the physical page in the same cycle. A fill writes a new translation into the first free slot. When no slot is free, a round-robin pointer picks the slot to overwrite.

A flush port removes translations selectively. The flush function code can come from four places: an immediate field, the low bits of a data register, or one of two 3-bit function-code registers. A 4-bit mask limits the compare to the chosen bits. The compare is qualified by the current task alias, and it can also be qualified by a page address. Shared slots survive every flush except a force flush or a flush-all. All chosen slots are cleared in one cycle.

Flush commands are privileged. A flush issued in user state changes nothing and raises a trap pulse instead.

Top module: `xlat_cache`

## Requirements
- R1: A flush-all command (`fl_all_i`=1) invalidates every slot, whatever its function code, task alias, page or shared flag.
- R2: A masked flush selects a slot only when (slot code AND `fl_mask_i`) equals (flush code AND `fl_mask_i`) on all 4 bits.
- R3: A masked flush selects only slots whose task alias equals `cur_task_i` in the cycle the flush is accepted.
- R4: When `fl_use_addr_i`=1, a masked flush also requires the slot's logical page to equal `fl_page_i`.
- R5: Shared slots (`fill_shared_i`=1 at fill) are kept by masked flushes, with or without an address. When `fl_force_i`=1, shared slots are selected like any other slot.
- R6: The flush code source is picked by `fl_src_i`:
  - 0 selects the `fl_imm_i` field.
  - 1 selects bits 3:0 of `fl_dreg_i`.
  - 2 selects `fl_sfc_i`.
  - 3 selects `fl_dfc_i`.
  - For sources 2 and 3, bit 3 of the code is zero.
- R7: A flush with `supervisor_i`=0 changes no slot. It raises `fl_trap_o` for exactly the one cycle after acceptance, and `fl_done_o` stays low.
- R8: A flush with `supervisor_i`=1 raises `fl_done_o` for exactly the one cycle after acceptance.
- R9: A lookup hits only when all of these hold:
  - the slot is valid;
  - the slot code equals `lk_fc_i` on all 4 bits;
  - the slot task alias equals `cur_task_i`, or the slot is shared;
  - the slot page equals `lk_page_i`.
  - On a hit, `lk_ppn_o` gives the stored physical page in the same cycle; on a miss it gives zero.
- R10: A fill writes the lowest-numbered invalid slot when one exists.
- R11: When every slot is valid, a fill overwrites the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, with wrap, on each such overwrite.
- R12: While `fl_valid_i` is high, `fill_ready_o` is low and the fill is not written. The flush takes effect.
- R13: After reset, every slot is invalid, `fl_done_o` and `fl_trap_o` are low, and `fill_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supervisor_i | input | 1 | Supervisor state |
| cur_task_i | input | TA_W | Active task alias |
| lk_fc_i | input | 4 | Lookup function code |
| lk_page_i | input | LP_W | Lookup logical page |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | PP_W | Physical page on hit |
| fill_valid_i | input | 1 | Fill request |
| fill_ready_o | output | 1 | Fill accepted this cycle |
| fill_fc_i | input | 4 | Fill function code |
| fill_task_i | input | TA_W | Fill task alias |
| fill_page_i | input | LP_W | Fill logical page |
| fill_ppn_i | input | PP_W | Fill physical page |
| fill_shared_i | input | 1 | Fill shared flag |
| fl_valid_i | input | 1 | Flush command |
| fl_all_i | input | 1 | Flush all slots |
| fl_force_i | input | 1 | Include shared slots |
| fl_use_addr_i | input | 1 | Qualify by page |
| fl_src_i | input | 2 | Code source select |
| fl_imm_i | input | 4 | Immediate code |
| fl_dreg_i | input | DREG_W | Data register value |
| fl_sfc_i | input | 3 | Source code register |
| fl_dfc_i | input | 3 | Destination code register |
| fl_mask_i | input | 4 | Code compare mask |
| fl_page_i | input | LP_W | Flush page address |
| fl_done_o | output | 1 | Flush completed pulse |
| fl_trap_o | output | 1 | Privilege trap pulse |

## Verification
A fill and a flush can be presented in the same cycle. The flush must win that clash. The bench provokes it by raising `fill_valid_i` and a flush-all command together, with a translation already loaded. It reads `fill_ready_o` in that cycle, then uses lookups to confirm that the preloaded translation was cleared and the held fill was never written. A later plain fill of the same translation must hit, which shows the fill was only held off and the slot was not corrupted.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int FC_W = 4;

  typedef enum logic [1:0] {
    FC_SRC_IMM  = 2'd0,
    FC_SRC_DREG = 2'd1,
    FC_SRC_SFC  = 2'd2,
    FC_SRC_DFC  = 2'd3
  } fc_src_e;
endpackage

// File: rtl/xc_fc_sel.sv
`timescale 1ns/1ps
module xc_fc_sel
  import xlat_pkg::*;
#(
  parameter int DREG_W = 32
) (
  input  logic [1:0]        src_i,
  input  logic [FC_W-1:0]   imm_i,
  input  logic [DREG_W-1:0] dreg_i,
  input  logic [2:0]        sfc_i,
  input  logic [2:0]        dfc_i,
  output logic [FC_W-1:0]   fc_o
);
  fc_src_e    src;
  logic       dreg_unused;

  assign src         = fc_src_e'(src_i);
  assign dreg_unused = ^dreg_i[DREG_W-1:FC_W];

  always_comb begin
    unique case (src)
      FC_SRC_IMM:  fc_o = imm_i;
      FC_SRC_DREG: fc_o = dreg_i[FC_W-1:0];
      FC_SRC_SFC:  fc_o = {1'b0, sfc_i};
      default:     fc_o = {1'b0, dfc_i};
    endcase
  end
endmodule

// File: rtl/xc_victim.sv
`timescale 1ns/1ps
module xc_victim #(
  parameter  int N     = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q, rr_d, first_free;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    logic found;
    found      = 1'b0;
    first_free = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !valid_i[i]) begin
        first_free = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end

  assign idx_o = full ? rr_q : first_free;

  always_comb begin
    rr_d = rr_q;
    if (alloc_i && full)
      rr_d = (rr_q == IDX_W'(N-1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !full) |-> !valid_i[idx_o]); // R10
  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && full && rr_q != IDX_W'(N-1)) |=> (rr_q == $past(rr_q) + 1'b1)); // R11
endmodule

// File: rtl/xc_entry_array.sv
`timescale 1ns/1ps
module xc_entry_array
  import xlat_pkg::*;
#(
  parameter  int N     = 16,
  parameter  int TA_W  = 3,
  parameter  int LP_W  = 20,
  parameter  int PP_W  = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [FC_W-1:0]  wr_fc,
  input  logic [TA_W-1:0]  wr_task,
  input  logic [LP_W-1:0]  wr_page,
  input  logic [PP_W-1:0]  wr_ppn,
  input  logic             wr_shared,
  input  logic             fl_en,
  input  logic             fl_all,
  input  logic             fl_force,
  input  logic             fl_use_addr,
  input  logic [FC_W-1:0]  fl_fc,
  input  logic [FC_W-1:0]  fl_mask,
  input  logic [TA_W-1:0]  fl_task,
  input  logic [LP_W-1:0]  fl_page,
  input  logic [FC_W-1:0]  lk_fc,
  input  logic [LP_W-1:0]  lk_page,
  input  logic [TA_W-1:0]  lk_task,
  output logic             lk_hit,
  output logic [PP_W-1:0]  lk_ppn,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0]           valid_q, valid_d, kill, hit_v, shared_v;
  logic [N-1:0][PP_W-1:0] ppn_v;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [FC_W-1:0] fc_r;
    logic [TA_W-1:0] task_r;
    logic [LP_W-1:0] page_r;
    logic [PP_W-1:0] ppn_r;
    logic            shared_r;
    logic            load, code_ok, task_ok, page_ok, keep_shared;

    assign load = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (load) begin
        fc_r     <= wr_fc;
        task_r   <= wr_task;
        page_r   <= wr_page;
        ppn_r    <= wr_ppn;
        shared_r <= wr_shared;
      end
    end

    assign code_ok     = ((fc_r & fl_mask) == (fl_fc & fl_mask));
    assign task_ok     = (task_r == fl_task);
    assign page_ok     = !fl_use_addr || (page_r == fl_page);
    assign keep_shared = shared_r && !fl_force;
    assign kill[i]     = fl_en && (fl_all || (code_ok && task_ok && page_ok && !keep_shared));

    assign hit_v[i]    = valid_q[i] && (fc_r == lk_fc) && (page_r == lk_page)
                         && ((task_r == lk_task) || shared_r);
    assign ppn_v[i]    = ppn_r;
    assign shared_v[i] = shared_r;
  end

  always_comb begin
    valid_d = valid_q & ~kill;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hit_v[i]) begin
        lk_hit = 1'b1;
        lk_ppn = ppn_v[i];
      end
    end
  end

  assign valid_o = valid_q;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, fl_en})); // R12
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && fl_all) |=> (valid_q == '0)); // R1
  AST_SHARED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !fl_all && !fl_force) |=> ((($past(valid_q) & shared_v) & ~valid_q) == '0)); // R5
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TA_W    = 3,
  parameter int LP_W    = 20,
  parameter int PP_W    = 20,
  parameter int DREG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supervisor_i,
  input  logic [TA_W-1:0]   cur_task_i,
  input  logic [3:0]        lk_fc_i,
  input  logic [LP_W-1:0]   lk_page_i,
  output logic              lk_hit_o,
  output logic [PP_W-1:0]   lk_ppn_o,
  input  logic              fill_valid_i,
  output logic              fill_ready_o,
  input  logic [3:0]        fill_fc_i,
  input  logic [TA_W-1:0]   fill_task_i,
  input  logic [LP_W-1:0]   fill_page_i,
  input  logic [PP_W-1:0]   fill_ppn_i,
  input  logic              fill_shared_i,
  input  logic              fl_valid_i,
  input  logic              fl_all_i,
  input  logic              fl_force_i,
  input  logic              fl_use_addr_i,
  input  logic [1:0]        fl_src_i,
  input  logic [3:0]        fl_imm_i,
  input  logic [DREG_W-1:0] fl_dreg_i,
  input  logic [2:0]        fl_sfc_i,
  input  logic [2:0]        fl_dfc_i,
  input  logic [3:0]        fl_mask_i,
  input  logic [LP_W-1:0]   fl_page_i,
  output logic              fl_done_o,
  output logic              fl_trap_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic               rst_meta, rst_sync;
  logic               fl_ok, fl_bad, fill_go;
  logic               done_q, done_d, trap_q, trap_d;
  logic [FC_W-1:0]    fl_fc;
  logic [IDX_W-1:0]   victim;
  logic [ENTRIES-1:0] valid_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign fl_ok        = fl_valid_i && supervisor_i;
  assign fl_bad       = fl_valid_i && !supervisor_i;
  assign fill_ready_o = !fl_valid_i;
  assign fill_go      = fill_valid_i && fill_ready_o;

  xc_fc_sel #(.DREG_W(DREG_W)) u_fc (
    .src_i (fl_src_i),
    .imm_i (fl_imm_i),
    .dreg_i(fl_dreg_i),
    .sfc_i (fl_sfc_i),
    .dfc_i (fl_dfc_i),
    .fc_o  (fl_fc)
  );

  xc_victim #(.N(ENTRIES)) u_vic (
    .clk    (clk),
    .rst_n  (rst_sync),
    .valid_i(valid_vec),
    .alloc_i(fill_go),
    .idx_o  (victim)
  );

  xc_entry_array #(.N(ENTRIES), .TA_W(TA_W), .LP_W(LP_W), .PP_W(PP_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_sync),
    .wr_en      (fill_go),
    .wr_idx     (victim),
    .wr_fc      (fill_fc_i),
    .wr_task    (fill_task_i),
    .wr_page    (fill_page_i),
    .wr_ppn     (fill_ppn_i),
    .wr_shared  (fill_shared_i),
    .fl_en      (fl_ok),
    .fl_all     (fl_all_i),
    .fl_force   (fl_force_i),
    .fl_use_addr(fl_use_addr_i),
    .fl_fc      (fl_fc),
    .fl_mask    (fl_mask_i),
    .fl_task    (cur_task_i),
    .fl_page    (fl_page_i),
    .lk_fc      (lk_fc_i),
    .lk_page    (lk_page_i),
    .lk_task    (cur_task_i),
    .lk_hit     (lk_hit_o),
    .lk_ppn     (lk_ppn_o),
    .valid_o    (valid_vec)
  );

  always_comb begin
    done_d = fl_ok;
    trap_d = fl_bad;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      done_q <= done_d;
      trap_q <= trap_d;
    end
  end

  assign fl_done_o = done_q;
  assign fl_trap_o = trap_q;

  AST_DONE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_sync)
    fl_ok |=> fl_done_o && !fl_trap_o); // R8
  AST_TRAP_ON_USER: assert property (@(posedge clk) disable iff (!rst_sync)
    fl_bad |=> fl_trap_o && !fl_done_o); // R7
  AST_USER_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_sync)
    fl_bad |=> $stable(valid_vec)); // R7
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_sync)
    (fl_valid_i && fill_valid_i && !fl_all_i && supervisor_i) |=> ($countones(valid_vec) <= $countones($past(valid_vec)))); // R12
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        supervisor_i;
  logic [2:0]  cur_task_i;
  logic [3:0]  lk_fc_i;
  logic [19:0] lk_page_i;
  logic        lk_hit_o;
  logic [19:0] lk_ppn_o;
  logic        fill_valid_i, fill_ready_o;
  logic [3:0]  fill_fc_i;
  logic [2:0]  fill_task_i;
  logic [19:0] fill_page_i, fill_ppn_i;
  logic        fill_shared_i;
  logic        fl_valid_i, fl_all_i, fl_force_i, fl_use_addr_i;
  logic [1:0]  fl_src_i;
  logic [3:0]  fl_imm_i, fl_mask_i;
  logic [31:0] fl_dreg_i;
  logic [2:0]  fl_sfc_i, fl_dfc_i;
  logic [19:0] fl_page_i;
  logic        fl_done_o, fl_trap_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic d1, t1, d2, t2;

  always #2 clk = ~clk;

  xlat_cache u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ppn_of(input logic [19:0] pg);
    return pg ^ 20'hA5000;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; supervisor_i = 1'b1; cur_task_i = '0;
    lk_fc_i = '0; lk_page_i = '0;
    fill_valid_i = 0; fill_fc_i = '0; fill_task_i = '0; fill_page_i = '0;
    fill_ppn_i = '0; fill_shared_i = 0;
    fl_valid_i = 0; fl_all_i = 0; fl_force_i = 0; fl_use_addr_i = 0;
    fl_src_i = '0; fl_imm_i = '0; fl_mask_i = '0; fl_dreg_i = '0;
    fl_sfc_i = '0; fl_dfc_i = '0; fl_page_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fill(input logic [3:0] fc, input logic [2:0] tk,
                      input logic [19:0] pg, input bit sh);
    @(negedge clk);
    fill_valid_i = 1; fill_fc_i = fc; fill_task_i = tk;
    fill_page_i = pg; fill_ppn_i = ppn_of(pg); fill_shared_i = sh;
    @(negedge clk);
    fill_valid_i = 0;
  endtask

  task automatic expect_look(input logic [3:0] fc, input logic [19:0] pg,
                             input logic [2:0] tk, input bit exp_hit,
                             input string req);
    cur_task_i = tk; lk_fc_i = fc; lk_page_i = pg;
    #1;
    chk(lk_hit_o == exp_hit, req, "lookup hit", 32'(lk_hit_o), 32'(exp_hit));
    if (exp_hit)
      chk(lk_ppn_o == ppn_of(pg), req, "lookup ppn", 32'(lk_ppn_o), 32'(ppn_of(pg)));
  endtask

  task automatic flush(input bit all, input bit force_sh, input bit use_addr,
                       input logic [1:0] src, input logic [3:0] imm,
                       input logic [31:0] dreg, input logic [2:0] sfc,
                       input logic [2:0] dfc, input logic [3:0] mask,
                       input logic [19:0] pg, input logic [2:0] tk, input bit sup);
    @(negedge clk);
    fl_valid_i = 1; fl_all_i = all; fl_force_i = force_sh; fl_use_addr_i = use_addr;
    fl_src_i = src; fl_imm_i = imm; fl_dreg_i = dreg; fl_sfc_i = sfc; fl_dfc_i = dfc;
    fl_mask_i = mask; fl_page_i = pg; cur_task_i = tk; supervisor_i = sup;
    @(negedge clk);
    fl_valid_i = 0; supervisor_i = 1;
    #1; d1 = fl_done_o; t1 = fl_trap_o;
    @(negedge clk);
    #1; d2 = fl_done_o; t2 = fl_trap_o;
  endtask

  task automatic t_reset();
    do_reset();
    chk(fl_done_o == 0, "R13", "done after reset", 32'(fl_done_o), 0);
    chk(fl_trap_o == 0, "R13", "trap after reset", 32'(fl_trap_o), 0);
    chk(fill_ready_o == 1, "R13", "ready after reset", 32'(fill_ready_o), 1);
    expect_look(4'd0, 20'd0, 3'd0, 0, "R13");
  endtask

  task automatic t_lookup();
    do_reset();
    fill(4'd5, 3'd2, 20'h00012, 0);
    fill(4'd6, 3'd4, 20'h00077, 1);
    expect_look(4'd5, 20'h00012, 3'd2, 1, "R9");
    expect_look(4'd4, 20'h00012, 3'd2, 0, "R9");
    expect_look(4'd5, 20'h00012, 3'd3, 0, "R9");
    expect_look(4'd5, 20'h00013, 3'd2, 0, "R9");
    expect_look(4'd6, 20'h00077, 3'd1, 1, "R9");
  endtask

  task automatic t_mask_task();
    do_reset();
    fill(4'd1, 3'd1, 20'h10, 0);
    fill(4'd2, 3'd1, 20'h20, 0);
    fill(4'd5, 3'd1, 20'h50, 0);
    fill(4'd6, 3'd1, 20'h60, 0);
    fill(4'd5, 3'd3, 20'h53, 0);
    flush(0, 0, 0, 2'd0, 4'b0001, 0, 0, 0, 4'b0011, 0, 3'd1, 1);
    chk(d1 == 1 && t1 == 0, "R8", "done pulse", 32'({d1, t1}), 32'b10);
    chk(d2 == 0, "R8", "done one cycle", 32'(d2), 0);
    expect_look(4'd1, 20'h10, 3'd1, 0, "R2");
    expect_look(4'd5, 20'h50, 3'd1, 0, "R2");
    expect_look(4'd2, 20'h20, 3'd1, 1, "R2");
    expect_look(4'd6, 20'h60, 3'd1, 1, "R2");
    expect_look(4'd5, 20'h53, 3'd3, 1, "R3");
  endtask

  task automatic t_addr();
    do_reset();
    fill(4'd1, 3'd1, 20'hA0, 0);
    fill(4'd1, 3'd1, 20'hB0, 0);
    flush(0, 0, 1, 2'd0, 4'd0, 0, 0, 0, 4'd0, 20'hA0, 3'd1, 1);
    expect_look(4'd1, 20'hA0, 3'd1, 0, "R4");
    expect_look(4'd1, 20'hB0, 3'd1, 1, "R4");
  endtask

  task automatic t_shared();
    do_reset();
    fill(4'd1, 3'd1, 20'hC0, 1);
    fill(4'd1, 3'd1, 20'hD0, 0);
    flush(0, 0, 0, 2'd0, 4'd0, 0, 0, 0, 4'd0, 0, 3'd1, 1);
    expect_look(4'd1, 20'hC0, 3'd1, 1, "R5");
    expect_look(4'd1, 20'hD0, 3'd1, 0, "R5");
    flush(0, 0, 1, 2'd0, 4'd0, 0, 0, 0, 4'd0, 20'hC0, 3'd1, 1);
    expect_look(4'd1, 20'hC0, 3'd1, 1, "R5");
    flush(0, 1, 0, 2'd0, 4'd0, 0, 0, 0, 4'd0, 0, 3'd1, 1);
    expect_look(4'd1, 20'hC0, 3'd1, 0, "R5");
  endtask

  task automatic t_all();
    do_reset();
    fill(4'd1, 3'd1, 20'h1, 1);
    fill(4'd7, 3'd5, 20'h2, 0);
    fill(4'd9, 3'd0, 20'h3, 0);
    flush(1, 0, 0, 2'd0, 4'd0, 0, 0, 0, 4'hF, 0, 3'd2, 1);
    expect_look(4'd1, 20'h1, 3'd1, 0, "R1");
    expect_look(4'd7, 20'h2, 3'd5, 0, "R1");
    expect_look(4'd9, 20'h3, 3'd0, 0, "R1");
  endtask

  task automatic t_src();
    do_reset();
    fill(4'd10, 3'd1, 20'h100, 0);
    fill(4'd2, 3'd1, 20'h200, 0);
    flush(0, 0, 0, 2'd1, 4'd0, 32'hFFFF_FFFA, 0, 0, 4'hF, 0, 3'd1, 1);
    expect_look(4'd10, 20'h100, 3'd1, 0, "R6");
    expect_look(4'd2, 20'h200, 3'd1, 1, "R6");
    flush(0, 0, 0, 2'd2, 4'd0, 0, 3'd2, 3'd0, 4'hF, 0, 3'd1, 1);
    expect_look(4'd2, 20'h200, 3'd1, 0, "R6");
    fill(4'd10, 3'd1, 20'h100, 0);
    fill(4'd2, 3'd1, 20'h200, 0);
    flush(0, 0, 0, 2'd3, 4'd0, 0, 3'd0, 3'd2, 4'hF, 0, 3'd1, 1);
    expect_look(4'd2, 20'h200, 3'd1, 0, "R6");
    expect_look(4'd10, 20'h100, 3'd1, 1, "R6");
  endtask

  task automatic t_priv();
    do_reset();
    fill(4'd3, 3'd1, 20'h30, 0);
    flush(1, 1, 0, 2'd0, 4'd0, 0, 0, 0, 4'd0, 0, 3'd1, 0);
    chk(t1 == 1 && d1 == 0, "R7", "trap pulse", 32'({t1, d1}), 32'b10);
    chk(t2 == 0, "R7", "trap one cycle", 32'(t2), 0);
    expect_look(4'd3, 20'h30, 3'd1, 1, "R7");
  endtask

  task automatic t_clash();
    do_reset();
    fill(4'd4, 3'd1, 20'h40, 0);
    @(negedge clk);
    fill_valid_i = 1; fill_fc_i = 4'd4; fill_task_i = 3'd1;
    fill_page_i = 20'h41; fill_ppn_i = ppn_of(20'h41); fill_shared_i = 0;
    fl_valid_i = 1; fl_all_i = 1; supervisor_i = 1;
    #1;
    chk(fill_ready_o == 0, "R12", "ready during flush", 32'(fill_ready_o), 0);
    @(negedge clk);
    fill_valid_i = 0; fl_valid_i = 0; fl_all_i = 0;
    #1;
    chk(fill_ready_o == 1, "R12", "ready after flush", 32'(fill_ready_o), 1);
    expect_look(4'd4, 20'h40, 3'd1, 0, "R12");
    expect_look(4'd4, 20'h41, 3'd1, 0, "R12");
    fill(4'd4, 3'd1, 20'h41, 0);
    expect_look(4'd4, 20'h41, 3'd1, 1, "R12");
  endtask

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < N; i++) fill(4'd1, 3'd1, 20'(i), 0);
    fill(4'd1, 3'd1, 20'd100, 0);
    expect_look(4'd1, 20'd0, 3'd1, 0, "R11");
    expect_look(4'd1, 20'd100, 3'd1, 1, "R11");
    for (int i = 1; i < N; i++) expect_look(4'd1, 20'(i), 3'd1, 1, "R11");
    fill(4'd1, 3'd1, 20'd101, 0);
    expect_look(4'd1, 20'd1, 3'd1, 0, "R11");
    flush(0, 0, 1, 2'd0, 4'd1, 0, 0, 0, 4'hF, 20'd5, 3'd1, 1);
    fill(4'd1, 3'd1, 20'd200, 0);
    expect_look(4'd1, 20'd200, 3'd1, 1, "R10");
    expect_look(4'd1, 20'd5, 3'd1, 0, "R10");
    for (int i = 2; i < N; i++)
      if (i != 5) expect_look(4'd1, 20'(i), 3'd1, 1, "R10");
  endtask

  initial begin
    t_reset();
    t_lookup();
    t_mask_task();
    t_addr();
    t_shared();
    t_all();
    t_src();
    t_priv();
    t_clash();
    t_replace();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule